// File: doc/BRIEF.md
# UART Transmit Path with Readable Fill Level

This block is the sending half of a serial port. Characters are pushed into a small transmit queue, taken out one at a time by a serializer, and shifted onto a single output line at a rate set by a programmable baud divider with 16x oversampling. The surrounding logic can see at any time how many characters are still waiting. It also gets two status flags, each with its own mask, that feed a single interrupt line. One flag reports that everything has gone out. The other reports that the queue has drained below a chosen level.

Frame shape is configured by static inputs: one or two stop bits, and an optional parity bit of selectable sense. A break input pulls the line low for as long as it is held, whatever the queue contains. A transmit enable gates the start of new characters. A flush input throws away the queued characters and any character already on the line. The baud generator has its own enable, and its divider input is written as the wanted division ratio minus one.

Top module: `uart_tx_path`

## Requirements
- R1: After reset `txd` is 1, `fill_level` is 0, `st_empty` is 1 and `irq` is 0.
- R2: A character is sent as a 0 start bit, then 8 data bits least-significant first, then a stop bit of 1. Each bit lasts 16*(`baud_div`+1) clock cycles. The line rests at 1 between frames.
- R3: With `par_en`=1, one parity bit follows the data. With `par_odd`=0 the data plus parity hold an even number of ones; with `par_odd`=1 they hold an odd number.
- R4: For characters sent back to back, the time from one start bit to the next is (10 + `par_en` + `two_stop`) bit times, within a few clock cycles.
- R5: `fill_level` equals the number of queued characters (0 to 16) one cycle after a write. Characters leave in the order they were written.
- R6: A write while 16 characters are queued is dropped: the fill level stays at 16 and the queued characters go out unchanged.
- R7: `st_empty` is 1 only when the queue is empty and no frame is on the line. It is 0 while the last character is still being shifted out.
- R8: `st_below` is 1 when `fill_level` < `tx_thresh` and 0 otherwise, two cycles after the level changes.
- R9: `irq` is (`st_empty` AND `mask_empty`) OR (`st_below` AND `mask_below`).
- R10: While `brk` is 1, `txd` is 0. When `brk` is released on an idle line, `txd` returns to 1.
- R11: While `tx_en` is 0, no new frame starts and the fill level is left as it is.
- R12: A `fifo_flush` pulse sets `fill_level` to 0 on the next cycle, abandons the frame in progress (the line returns to 1), and drops a write made in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Push `wr_data` into the queue |
| wr_data | input | 8 | Character to queue |
| tx_en | input | 1 | Allow new frames to start |
| baud_en | input | 1 | Run the baud divider |
| baud_div | input | 16 | Division ratio minus one |
| two_stop | input | 1 | 1 = two stop bits |
| par_en | input | 1 | Append a parity bit |
| par_odd | input | 1 | 1 = odd parity, 0 = even |
| brk | input | 1 | Hold the line low |
| fifo_flush | input | 1 | Discard queued and in-flight data |
| tx_thresh | input | 5 | Level under which `st_below` is set |
| mask_empty | input | 1 | Let `st_empty` reach `irq` |
| mask_below | input | 1 | Let `st_below` reach `irq` |
| fill_level | output | 5 | Number of queued characters |
| st_empty | output | 1 | Queue and serializer both idle |
| st_below | output | 1 | Fill level under threshold |
| irq | output | 1 | Masked status interrupt |
| txd | output | 1 | Serial output line |

## Verification
The flush and a write can land in the same clock. The bench preloads two characters with the transmitter gated, then raises `fifo_flush` and `wr_en` together for one cycle. It expects a fill level of zero and a line that stays high after the transmitter is enabled. A write into a full queue is the second collision. The bench sends a seventeenth character into a queue holding sixteen and judges the case by the sixteen frames that follow, which must match the first sixteen writes in order.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_START,
    S_DATA,
    S_PAR,
    S_STOP
  } tx_state_t;
endpackage

// File: rtl/uart_txq.sv
module uart_txq #(
  parameter int DEPTH = 16,
  parameter int W     = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         flush,
  input  logic                         push,
  input  logic [W-1:0]                 push_data,
  input  logic                         pop,
  output logic [W-1:0]                 head,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic                         empty
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          do_push, do_pop;

  assign empty   = (count == '0);
  assign do_push = push && !flush && (count != CW'(DEPTH));
  assign do_pop  = pop && !flush && !empty;
  assign head    = mem[rd_ptr];

  // storage without reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R5
  fill_bound_chk: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));

  // R6
  full_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (push && !pop && !flush && count == CW'(DEPTH)) |=> $stable(count));

  // R12
  flush_clear_chk: assert property (@(posedge clk) disable iff (rst)
    flush |=> (count == '0));
endmodule

// File: rtl/uart_baudgen.sv
module uart_baudgen #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == '0) begin
      cnt  <= div;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt - 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_tx_shifter.sv
module uart_tx_shifter
  import uart_tx_pkg::*;
#(
  parameter int W  = 8,
  parameter int OS = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         tx_en,
  input  logic         abort,
  input  logic         two_stop,
  input  logic         par_en,
  input  logic         par_odd,
  input  logic         brk,
  input  logic         avail,
  input  logic [W-1:0] head,
  output logic         pop,
  output logic         busy,
  output logic         txd
);
  localparam int OSW = $clog2(OS);
  localparam int BW  = (W > 1) ? $clog2(W) : 1;

  tx_state_t      state;
  logic [OSW-1:0] os_cnt;
  logic [BW-1:0]  bit_idx;
  logic [W-1:0]   shreg;
  logic           par_bit;
  logic           stop_idx;
  logic           line_bit;
  logic           load;

  assign load = tx_en && avail && !abort && (state == S_IDLE);
  assign pop  = load;
  assign busy = (state != S_IDLE);

  always_comb begin
    case (state)
      S_START: line_bit = 1'b0;
      S_DATA:  line_bit = shreg[0];
      S_PAR:   line_bit = par_bit;
      default: line_bit = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      os_cnt   <= '0;
      bit_idx  <= '0;
      shreg    <= '0;
      par_bit  <= 1'b0;
      stop_idx <= 1'b0;
      txd      <= 1'b1;
    end else begin
      txd <= brk ? 1'b0 : line_bit;
      if (abort) begin
        state  <= S_IDLE;
        os_cnt <= '0;
      end else if (load) begin
        shreg    <= head;
        par_bit  <= (^head) ^ par_odd;
        state    <= S_START;
        os_cnt   <= '0;
        bit_idx  <= '0;
        stop_idx <= 1'b0;
      end else if (tick && state != S_IDLE) begin
        if (os_cnt == OSW'(OS-1)) begin
          os_cnt <= '0;
          case (state)
            S_START: state <= S_DATA;
            S_DATA: begin
              shreg <= shreg >> 1;
              if (bit_idx == BW'(W-1)) begin
                bit_idx <= '0;
                state   <= par_en ? S_PAR : S_STOP;
              end else begin
                bit_idx <= bit_idx + 1'b1;
              end
            end
            S_PAR: state <= S_STOP;
            S_STOP: begin
              if (two_stop && !stop_idx) stop_idx <= 1'b1;
              else                       state    <= S_IDLE;
            end
            default: state <= S_IDLE;
          endcase
        end else begin
          os_cnt <= os_cnt + 1'b1;
        end
      end
    end
  end

  // R10
  brk_low_chk: assert property (@(posedge clk) disable iff (rst)
    brk |=> !txd);

  // R11
  hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (state == S_IDLE && !tx_en) |=> (state == S_IDLE));
endmodule

// File: rtl/uart_tx_path.sv
module uart_tx_path #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8,
  parameter int DIV_W  = 16,
  parameter int OS     = 16,
  localparam int CW    = $clog2(DEPTH+1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              tx_en,
  input  logic              baud_en,
  input  logic [DIV_W-1:0]  baud_div,
  input  logic              two_stop,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              brk,
  input  logic              fifo_flush,
  input  logic [CW-1:0]     tx_thresh,
  input  logic              mask_empty,
  input  logic              mask_below,
  output logic [CW-1:0]     fill_level,
  output logic              st_empty,
  output logic              st_below,
  output logic              irq,
  output logic              txd
);
  logic              tick, pop, busy, q_empty;
  logic [DATA_W-1:0] head;
  logic              empty_nx, below_nx;

  uart_txq #(.DEPTH(DEPTH), .W(DATA_W)) u_q (
    .clk(clk), .rst(rst), .flush(fifo_flush), .push(wr_en),
    .push_data(wr_data), .pop(pop), .head(head),
    .count(fill_level), .empty(q_empty)
  );

  uart_baudgen #(.DIV_W(DIV_W)) u_baud (
    .clk(clk), .rst(rst), .en(baud_en), .div(baud_div), .tick(tick)
  );

  uart_tx_shifter #(.W(DATA_W), .OS(OS)) u_sh (
    .clk(clk), .rst(rst), .tick(tick), .tx_en(tx_en), .abort(fifo_flush),
    .two_stop(two_stop), .par_en(par_en), .par_odd(par_odd), .brk(brk),
    .avail(!q_empty), .head(head), .pop(pop), .busy(busy), .txd(txd)
  );

  assign empty_nx = q_empty && !busy;
  assign below_nx = (fill_level < tx_thresh);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_empty <= 1'b1;
      st_below <= 1'b0;
      irq      <= 1'b0;
    end else begin
      st_empty <= empty_nx;
      st_below <= below_nx;
      irq      <= (empty_nx && mask_empty) || (below_nx && mask_below);
    end
  end

  // R7
  empty_flag_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(busy) || $past(fill_level) != '0) |-> !st_empty);
endmodule

// File: tb/tb_uart_tx_path.sv
module tb_uart_tx_path;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       tx_en = 1'b1, baud_en = 1'b1;
  logic [15:0] baud_div = 16'd1;
  logic       two_stop = 1'b0, par_en = 1'b0, par_odd = 1'b0, brk = 1'b0;
  logic       fifo_flush = 1'b0;
  logic [4:0] tx_thresh = 5'd8;
  logic       mask_empty = 1'b0, mask_below = 1'b0;
  logic [4:0] fill_level;
  logic       st_empty, st_below, irq, txd;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  uart_tx_path dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .tx_en(tx_en),
    .baud_en(baud_en), .baud_div(baud_div), .two_stop(two_stop),
    .par_en(par_en), .par_odd(par_odd), .brk(brk), .fifo_flush(fifo_flush),
    .tx_thresh(tx_thresh), .mask_empty(mask_empty), .mask_below(mask_below),
    .fill_level(fill_level), .st_empty(st_empty), .st_below(st_below),
    .irq(irq), .txd(txd)
  );

  function automatic int bit_t();
    return 16 * (int'(baud_div) + 1);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic put(input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_fall(output int t);
    while (txd !== 1'b1) @(negedge clk);
    while (txd === 1'b1) @(negedge clk);
    t = cyc;
  endtask

  // call right after wait_fall; samples mid-bit
  task automatic recv(output logic [7:0] d, output logic p, output logic stp);
    int tb = bit_t();
    d = '0; p = 1'b0;
    wait_cyc(tb / 2);
    for (int i = 0; i < 8; i++) begin
      wait_cyc(tb);
      d[i] = txd;
    end
    if (par_en) begin wait_cyc(tb); p = txd; end
    wait_cyc(tb);
    stp = txd;
    if (two_stop) begin wait_cyc(tb); stp = stp & txd; end
  endtask

  task automatic t_reset();
    wait_cyc(2);
    chk("R1 txd", int'(txd), 1);
    chk("R1 fill", int'(fill_level), 0);
    chk("R1 st_empty", int'(st_empty), 1);
    chk("R1 irq", int'(irq), 0);
  endtask

  task automatic t_frame();
    logic [7:0] d; logic p, s; int t;
    put(8'hA5);
    wait_fall(t);
    recv(d, p, s);
    chk("R2 data A5", int'(d), 'hA5);
    chk("R2 stop", int'(s), 1);
    put(8'h3C);
    wait_fall(t);
    recv(d, p, s);
    chk("R2 data 3C", int'(d), 'h3C);
    wait_cyc(bit_t());
    chk("R2 idle high", int'(txd), 1);
  endtask

  task automatic t_parity();
    logic [7:0] d; logic p, s; int t;
    par_en = 1'b1; par_odd = 1'b0;
    put(8'h07); wait_fall(t); recv(d, p, s);
    chk("R3 even parity of 07", int'(p), 1);
    par_odd = 1'b1;
    wait_cyc(bit_t());
    put(8'h07); wait_fall(t); recv(d, p, s);
    chk("R3 odd parity of 07", int'(p), 0);
    put(8'h00); wait_fall(t); recv(d, p, s);
    chk("R3 odd parity of 00", int'(p), 1);
    chk("R3 data", int'(d), 0);
    par_en = 1'b0; par_odd = 1'b0;
    wait_cyc(bit_t());
  endtask

  task automatic gap(input int nbits, input string req);
    logic [7:0] d; logic p, s; int t0, t1, diff;
    tx_en = 1'b0;
    put(8'h81); put(8'h55);
    @(negedge clk); tx_en = 1'b1;
    wait_fall(t0);
    recv(d, p, s);
    wait_fall(t1);
    recv(d, p, s);
    diff = t1 - t0 - nbits * bit_t();
    chk(req, (diff >= -1 && diff <= 4) ? nbits * bit_t() : t1 - t0,
        nbits * bit_t());
    wait_cyc(bit_t());
  endtask

  task automatic t_stops();
    gap(10, "R4 interval 1 stop");
    par_en = 1'b1; two_stop = 1'b1;
    gap(12, "R4 interval parity 2 stop");
    par_en = 1'b0; two_stop = 1'b0;
  endtask

  task automatic t_fill();
    logic [7:0] d; logic p, s; int t; int bad;
    baud_div = 16'd0;
    tx_en = 1'b0;
    for (int i = 0; i < 16; i++) begin
      put(8'(i * 17 + 1));
      if (i == 6) begin
        wait_cyc(2);
        chk("R8 below at 7", int'(st_below), 1);
      end
      if (i == 7) begin
        wait_cyc(2);
        chk("R8 not below at 8", int'(st_below), 0);
      end
    end
    chk("R5 fill 16", int'(fill_level), 16);
    put(8'hFF);
    chk("R6 fill stays 16", int'(fill_level), 16);
    @(negedge clk); tx_en = 1'b1;
    bad = 0;
    for (int i = 0; i < 16; i++) begin
      wait_fall(t);
      if (i == 15) begin
        wait_cyc(3);
        chk("R7 busy last char", int'(st_empty), 0);
        wait_cyc(bit_t() / 2 - 3);
        wait_cyc(-bit_t() / 2 + bit_t() / 2);
      end
      if (i == 15) begin
        recv_rest(d, t);
      end else begin
        recv(d, p, s);
      end
      if (d != 8'(i * 17 + 1)) bad++;
    end
    chk("R6 R5 order and contents", bad, 0);
    wait_cyc(2 * bit_t());
    chk("R7 empty after drain", int'(st_empty), 1);
    baud_div = 16'd1;
  endtask

  // receive a frame whose start edge was seen bit_t()/2 cycles ago
  task automatic recv_rest(output logic [7:0] d, output int dummy);
    int tb = bit_t();
    d = '0; dummy = 0;
    for (int i = 0; i < 8; i++) begin
      wait_cyc(tb);
      d[i] = txd;
    end
    wait_cyc(tb);
  endtask

  task automatic t_irq();
    tx_thresh = 5'd8; mask_below = 1'b1; mask_empty = 1'b0;
    wait_cyc(3);
    chk("R9 below masked in", int'(irq), 1);
    tx_thresh = 5'd0;
    wait_cyc(3);
    chk("R9 nothing pending", int'(irq), 0);
    mask_empty = 1'b1;
    wait_cyc(3);
    chk("R9 empty masked in", int'(irq), 1);
    mask_empty = 1'b0; mask_below = 1'b0; tx_thresh = 5'd8;
    wait_cyc(3);
    chk("R9 all masked", int'(irq), 0);
  endtask

  task automatic t_break();
    int low = 1;
    @(negedge clk); brk = 1'b1;
    wait_cyc(2);
    for (int i = 0; i < 100; i++) begin
      if (txd !== 1'b0) low = 0;
      @(negedge clk);
    end
    chk("R10 line held low", low, 1);
    brk = 1'b0;
    wait_cyc(3);
    chk("R10 line released", int'(txd), 1);
  endtask

  task automatic t_gate();
    int high = 1;
    tx_en = 1'b0;
    put(8'h00);
    for (int i = 0; i < 3 * bit_t(); i++) begin
      if (txd !== 1'b1) high = 0;
      @(negedge clk);
    end
    chk("R11 no frame while gated", high, 1);
    chk("R11 fill kept", int'(fill_level), 1);
    @(negedge clk); fifo_flush = 1'b1;
    @(negedge clk); fifo_flush = 1'b0;
    chk("R12 flush empties", int'(fill_level), 0);
    tx_en = 1'b1;
    high = 1;
    for (int i = 0; i < 2 * bit_t(); i++) begin
      if (txd !== 1'b1) high = 0;
      @(negedge clk);
    end
    chk("R12 flushed char not sent", high, 1);
  endtask

  task automatic t_abort();
    int t; int high = 1;
    put(8'h00);
    wait_fall(t);
    wait_cyc(2 * bit_t());
    @(negedge clk); fifo_flush = 1'b1;
    @(negedge clk); fifo_flush = 1'b0;
    wait_cyc(2);
    for (int i = 0; i < 10 * bit_t(); i++) begin
      if (txd !== 1'b1) high = 0;
      @(negedge clk);
    end
    chk("R12 frame abandoned", high, 1);
    chk("R12 R7 empty after abort", int'(st_empty), 1);
  endtask

  task automatic t_collide();
    int high = 1;
    tx_en = 1'b0;
    put(8'h11); put(8'h22);
    @(negedge clk);
    fifo_flush = 1'b1; wr_en = 1'b1; wr_data = 8'h33;
    @(negedge clk);
    fifo_flush = 1'b0; wr_en = 1'b0;
    chk("R12 write with flush dropped", int'(fill_level), 0);
    tx_en = 1'b1;
    for (int i = 0; i < 2 * bit_t(); i++) begin
      if (txd !== 1'b1) high = 0;
      @(negedge clk);
    end
    chk("R12 nothing sent after collision", high, 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait_cyc(4);
    rst = 1'b0;
    t_reset();
    t_frame();
    t_parity();
    t_stops();
    t_fill();
    t_irq();
    t_break();
    t_gate();
    t_abort();
    t_collide();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule